// File: doc/BRIEF.md
# Horizontal Sync Output Regenerator

This block turns a horizontal sync of either polarity into a clean, active-high sync pulse that is timed to the data clock. A configuration input states which level of the incoming sync is active. Only the edge that goes into that level starts an output pulse. The output pulse then ends when the incoming pulse ends. There is one exception: if the incoming pulse is still active at the middle of the line, the output is cut off there.

The middle of the line is half of a programmable line length, given in data clocks and counted from the leading edge. The incoming sync is asynchronous. It passes through a two-stage synchronizer before any edge is detected, so every output transition comes a fixed number of clocks after the input transition that caused it.

A polarity setting that does not match the source is easy to recognise. In that case the block treats the long inactive gap as the pulse, and the mid-line cut-off then produces an output that is high for about half of every line.

Top module: `hsync_regen`

## Requirements
- R1: While `rst_n` is low, and after reset until the first leading edge, `hs_out` is 0.
- R2: With `sync_act_high` = 1, a 0-to-1 transition of `hs_in` is the leading edge. `hs_out` goes to 1 after the third rising clock edge that follows the transition, with no clock edge sampling the new input level before the first of those three.
- R3: With `sync_act_high` = 0, a 1-to-0 transition of `hs_in` is the leading edge. `hs_out` is still active high and has the same three-edge latency.
- R4: When the input returns to its inactive level before mid-line, `hs_out` falls with the same three-edge latency. The output pulse is then exactly as wide as the input pulse.
- R5: When the input is still active, `hs_out` is forced to 0 after it has been high for H clocks. H = floor(`line_len`/2), with a minimum of 1.
- R6: After being forced low, `hs_out` stays 0 while the input remains active and through its trailing edge. Only a new leading edge raises it again.
- R7: An input transition into the inactive level never raises `hs_out`.
- R8: When the polarity setting is the inverse of the source, each line gives exactly H output clocks high, which is about a 50% duty cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Data clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hs_in | input | 1 | Incoming horizontal sync, asynchronous |
| sync_act_high | input | 1 | 1: input active high; 0: input active low |
| line_len | input | LEN_W | Line length in data clocks |
| hs_out | output | 1 | Regenerated sync, active high |

## Verification
The hardest state to reach from the ports is a forced-low output that then has to stay low. That needs an input pulse longer than half the line, followed by its late trailing edge and then a fresh leading edge, all with the three-clock pipeline lined up. The stimulus produces this with over-long pulses on even and odd line lengths, down to the smallest half-length of one clock. It also drives short active-high pulses with the polarity set inverted, and counts the output-high clocks against H per line.

// File: rtl/hsr_pkg.sv
package hsr_pkg;

  // Number of synchronizer flops ahead of edge detection.
  localparam int unsigned SYNC_DEPTH = 2;

  // Mid-line point: half of the line length, never below one clock.
  function automatic int unsigned mid_of(input int unsigned len);
    int unsigned h;
    h = len >> 1;
    if (h < 1) h = 1;
    return h;
  endfunction

  // Normalize a raw sync level to "active" given the polarity setting.
  function automatic logic to_active(input logic level, input logic act_high);
    return act_high ? level : ~level;
  endfunction

endpackage

// File: rtl/hsr_sync.sv
module hsr_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/hsr_edge.sv
module hsr_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic level,
  input  logic act_high,
  output logic lead,
  output logic trail
);
  logic act_now;
  logic act_prev;

  assign act_now = hsr_pkg::to_active(level, act_high);

  // Previous level resets to "active" so that no leading edge is seen
  // before the input has first been observed inactive.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_prev <= 1'b1;
    else        act_prev <= act_now;
  end

  assign lead  = act_now & ~act_prev;
  assign trail = ~act_now & act_prev;

  a_r7_lead_needs_active: assert property (@(posedge clk) disable iff (!rst_n)
    lead |=> act_prev);
endmodule

// File: rtl/hsr_midline_timer.sv
module hsr_midline_timer #(
  parameter int unsigned LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             stop,
  input  logic [LEN_W-1:0] line_len,
  output logic             mid_hit
);
  localparam int unsigned CNT_W = LEN_W;

  logic [CNT_W-1:0] half;
  logic [CNT_W-1:0] cnt;
  logic             run;

  assign half = CNT_W'(hsr_pkg::mid_of(32'(line_len)));

  // cnt holds the number of clocks the output has been high.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (start) begin
      run <= 1'b1;
      cnt <= CNT_W'(1);
    end else if (stop || mid_hit) begin
      run <= 1'b0;
    end else if (run) begin
      cnt <= cnt + CNT_W'(1);
    end
  end

  assign mid_hit = run && (cnt == half);

  a_r5_count_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $stable(line_len)) |-> (cnt <= half));
endmodule

// File: rtl/hsync_regen.sv
module hsync_regen #(
  parameter int unsigned LEN_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hs_in,
  input  logic             sync_act_high,
  input  logic [LEN_W-1:0] line_len,
  output logic             hs_out
);
  logic hs_synced;
  logic lead;
  logic trail;
  logic mid_hit;

  hsr_sync #(.STAGES(hsr_pkg::SYNC_DEPTH)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (hs_in),
    .dout (hs_synced)
  );

  hsr_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .level   (hs_synced),
    .act_high(sync_act_high),
    .lead    (lead),
    .trail   (trail)
  );

  hsr_midline_timer #(.LEN_W(LEN_W)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (lead),
    .stop    (trail),
    .line_len(line_len),
    .mid_hit (mid_hit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                hs_out <= 1'b0;
    else if (lead)             hs_out <= 1'b1;
    else if (trail || mid_hit) hs_out <= 1'b0;
  end

  // R2 / R3: a leading edge raises the output on the next clock.
  a_r2_lead_raises: assert property (@(posedge clk) disable iff (!rst_n)
    lead |=> hs_out);
  // R4: a trailing edge drops the output.
  a_r4_trail_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (trail && !lead) |=> !hs_out);
  // R5: reaching mid-line drops the output.
  a_r5_mid_drops: assert property (@(posedge clk) disable iff (!rst_n)
    (mid_hit && !lead) |=> !hs_out);
  // R6: the output only rises after a leading edge.
  a_r6_rise_only_on_lead: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_out) |-> $past(lead));
endmodule

// File: tb/tb_hsync_regen.sv
module tb_hsync_regen;
  localparam int LEN_W = 12;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             hs_in = 1'b0;
  logic             sync_act_high = 1'b1;
  logic [LEN_W-1:0] line_len = LEN_W'(20);
  logic             hs_out;

  hsync_regen #(.LEN_W(LEN_W)) dut (
    .clk(clk), .rst_n(rst_n), .hs_in(hs_in),
    .sync_act_high(sync_act_high), .line_len(line_len), .hs_out(hs_out)
  );

  always #10 clk = ~clk;

  typedef struct { bit exp; string tag; } item_t;
  item_t q[$];
  int    checks = 0;
  int    fails  = 0;
  int    ones   = 0;
  string cur_tag = "R1";
  bit    m_prev, m_out;
  int    m_age;

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  task automatic check(input bit got, input bit exp, input string tag);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: hs_out=%0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  // Driver: one input level per clock; reference model pushes the result.
  task automatic step(input bit v);
    bit a;
    int h;
    @(negedge clk);
    hs_in = v;
    a = sync_act_high ? v : ~v;
    h = int'(line_len) / 2;
    if (h < 1) h = 1;
    if (a && !m_prev) begin
      m_out = 1'b1;
      m_age = 1;
    end else if (m_out) begin
      if (!a || m_age >= h) m_out = 1'b0;
      else m_age++;
    end
    m_prev = a;
    q.push_back('{m_out, cur_tag});
  endtask

  // Monitor: result of a step is visible three clocks after it.
  always @(negedge clk) begin
    item_t it;
    #2;
    if (rst_n && q.size() >= 4) begin
      it = q.pop_front();
      check(hs_out, it.exp, it.tag);
      if (hs_out) ones++;
    end
  end

  task automatic do_reset(input bit act_high, input int len, input bit idle);
    @(negedge clk);
    rst_n = 1'b0;
    sync_act_high = act_high;
    line_len = LEN_W'(len);
    hs_in = idle;
    q.delete();
    m_prev = 1'b1;
    m_out = 1'b0;
    m_age = 0;
    ones = 0;
    repeat (2) begin
      @(negedge clk);
      #2 check(hs_out, 1'b0, "R1 (in reset)");
    end
    rst_n = 1'b1;
  endtask

  task automatic line(input bit idle, input int width, input int len);
    for (int i = 0; i < len; i++) step(i < width ? ~idle : idle);
  endtask

  task automatic idle_run(input bit idle, input int n);
    for (int i = 0; i < n; i++) step(idle);
  endtask

  initial begin
    #4ms;
    checks++;
    fails++;
    $display("FAIL watchdog: run hung, expected completion");
    summary();
    $finish;
  end

  initial begin
    // R1 then R2 / R4 / R7: active-high source, short pulses.
    do_reset(1'b1, 20, 1'b0);
    cur_tag = "R1"; idle_run(1'b0, 6);
    cur_tag = "R2 R4 R7 active-high short pulse";
    repeat (3) line(1'b0, 4, 20);
    idle_run(1'b0, 4);

    // R3 / R4 / R7: active-low source.
    do_reset(1'b0, 20, 1'b1);
    cur_tag = "R1"; idle_run(1'b1, 6);
    cur_tag = "R3 R4 R7 active-low short pulse";
    repeat (3) line(1'b1, 5, 20);
    idle_run(1'b1, 4);

    // R5 / R6: over-long pulse, even line length (H=8).
    do_reset(1'b1, 16, 1'b0);
    idle_run(1'b0, 4);
    cur_tag = "R5 R6 long pulse H=8";
    repeat (3) line(1'b0, 13, 16);
    idle_run(1'b0, 4);

    // R5 / R6: odd line length (H=4), active-low source.
    do_reset(1'b0, 9, 1'b1);
    idle_run(1'b1, 4);
    cur_tag = "R5 R6 odd length H=4";
    repeat (3) line(1'b1, 7, 9);
    idle_run(1'b1, 4);

    // R5: minimum half-length of one clock (line_len 1 and 2).
    do_reset(1'b1, 1, 1'b0);
    idle_run(1'b0, 4);
    cur_tag = "R5 H=1 len=1";
    repeat (2) line(1'b0, 5, 8);
    idle_run(1'b0, 4);
    do_reset(1'b1, 2, 1'b0);
    idle_run(1'b0, 4);
    cur_tag = "R5 H=1 len=2";
    repeat (2) line(1'b0, 5, 8);
    idle_run(1'b0, 4);

    // R8: source active high, polarity set to active low: 3 lines of 24.
    do_reset(1'b0, 24, 1'b0);
    cur_tag = "R8 inverted polarity";
    repeat (3) line(1'b0, 3, 24);
    idle_run(1'b0, 20);
    checks++;
    if (ones != 3 * 12) begin
      fails++;
      $display("FAIL R8: high clocks=%0d expected %0d (half of each line)", ones, 36);
    end

    summary();
    $finish;
  end
endmodule